// File: doc/BRIEF.md
# Idle Standby and Protection Gate

This block sits between the two direction/PWM command inputs of a full-bridge motor driver and the power stage. It watches for both command inputs being low together. The moment that happens, it tells the bridge to coast, with every output in high impedance. If the idle condition lasts past a programmable number of clock ticks, it asks the analog side to power down the charge pump and internal regulator.

When either command input rises again, the block drops the power-down request and emits a one-cycle pulse that clears any latched overcurrent fault. It then keeps the bridge disabled for a programmable settling window so the charge pump can reach regulation before commands pass through.

Independently of that sequence, an undervoltage flag and a thermal-shutdown flag from external comparators gate the bridge. Undervoltage acts immediately and for exactly as long as it is present. An over-temperature event is latched until a separate cool-down flag reports that the die has recovered.

Top module: `stby_gate`

## Requirements
- R1: While reset is high and on the cycle after it is released, `standby_req` and `wake_clr` are 0.
- R2: `standby_req` rises on the clock edge that samples both command inputs low for the (IDLE_TICKS+1)-th consecutive edge, and not earlier.
- R3: A single sampled edge with either command input high restarts the idle count, so a new full run of IDLE_TICKS+1 low edges is needed.
- R4: `force_hiz` is 1 in the same cycle in which both command inputs are low, including before standby is entered.
- R5: `standby_req` stays 1 while both inputs remain low, and falls on the first edge that samples either input high.
- R6: `wake_clr` is 1 for exactly one cycle, the cycle right after `standby_req` falls.
- R7: After a wake, `bridge_ready` stays 0 for SETTLE_TICKS edges and becomes 1 on edge SETTLE_TICKS+1 (protection flags clear).
- R8: While `uv_flag` is 1, `bridge_ready` is 0 and `force_hiz` is 1 in that same cycle; both recover as soon as it falls.
- R9: `ot_flag` high clears `bridge_ready` at once. After `ot_flag` falls, `bridge_ready` stays 0 until an edge samples `ot_cool` high.
- R10: `standby_req` and `bridge_ready` are never 1 together, and `force_hiz` is 1 whenever `bridge_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_a | input | 1 | Bridge command input A |
| cmd_b | input | 1 | Bridge command input B |
| uv_flag | input | 1 | Supply undervoltage flag, hysteresis already applied |
| ot_flag | input | 1 | Over-temperature flag |
| ot_cool | input | 1 | Temperature has fallen below the recovery point |
| standby_req | output | 1 | Power down charge pump and regulator |
| wake_clr | output | 1 | One-cycle pulse on standby exit; clears a latched overcurrent fault |
| bridge_ready | output | 1 | Bridge may follow commands |
| force_hiz | output | 1 | Force all bridge outputs to high impedance |

## Verification
The bench drives the idle count one edge short of the limit and then blips an input high for a single edge. A design that counts total rather than consecutive low edges, or that trips one edge early, would then enter standby where it must not. It checks that coasting happens in the same cycle as the inputs drop, not only once standby is reached. It checks that the fault-clear pulse is exactly one cycle wide, and that the settling window has exactly the configured length, so an off-by-one in either direction shows up. A thermal sequence drops the over-temperature flag before raising the cool-down flag. A design that does not latch the over-temperature condition would re-enable the bridge too early.

// File: rtl/stby_gate_pkg.sv
package stby_gate_pkg;

    typedef enum logic [1:0] {
        PH_RUN    = 2'd0,
        PH_SLEEP  = 2'd1,
        PH_SETTLE = 2'd2
    } phase_e;

    typedef struct packed {
        logic sleep;
        logic wake_pulse;
        logic run;
    } seq_out_t;

    function automatic int unsigned cnt_bits(int unsigned a, int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/stby_seq.sv
module stby_seq
    import stby_gate_pkg::*;
#(
    parameter int unsigned IDLE_TICKS   = 125000,
    parameter int unsigned SETTLE_TICKS = 25000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_a,
    input  logic     cmd_b,
    output seq_out_t so
);
    localparam int unsigned CW = cnt_bits(IDLE_TICKS, SETTLE_TICKS);
    localparam logic [CW-1:0] IDLE_LIM   = CW'(IDLE_TICKS);
    localparam logic [CW-1:0] SETTLE_LIM = CW'(SETTLE_TICKS - 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic          pulse_q;
    logic          both_low;

    assign both_low = !cmd_a && !cmd_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            unique case (phase_q)
                PH_RUN: begin
                    if (!both_low) begin
                        cnt_q <= '0;
                    end else if (cnt_q == IDLE_LIM) begin
                        phase_q <= PH_SLEEP;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_SLEEP: begin
                    if (!both_low) begin
                        phase_q <= PH_SETTLE;
                        cnt_q   <= '0;
                        pulse_q <= 1'b1;
                    end
                end
                PH_SETTLE: begin
                    if (cnt_q == SETTLE_LIM) begin
                        phase_q <= PH_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_RUN;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign so.sleep      = (phase_q == PH_SLEEP);
    assign so.wake_pulse = pulse_q;
    assign so.run        = (phase_q == PH_RUN);

    p_sleep_entry_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(so.sleep) |-> $past(!cmd_a && !cmd_b));

    p_wake_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (so.sleep && (cmd_a || cmd_b)) |=> (!so.sleep && so.wake_pulse));

    p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
        so.wake_pulse |=> !so.wake_pulse);

    p_one_phase_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({so.sleep, so.run}));

endmodule

// File: rtl/stby_therm.sv
module stby_therm (
    input  logic clk,
    input  logic rst,
    input  logic ot_flag,
    input  logic ot_cool,
    output logic hot_lock
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hot_lock <= 1'b0;
        end else if (ot_flag) begin
            hot_lock <= 1'b1;
        end else if (ot_cool) begin
            hot_lock <= 1'b0;
        end
    end

    p_hold_until_cool_r9: assert property (@(posedge clk) disable iff (rst)
        (hot_lock && !ot_flag && !ot_cool) |=> hot_lock);

    p_set_on_hot_r9: assert property (@(posedge clk) disable iff (rst)
        ot_flag |=> hot_lock);

endmodule

// File: rtl/stby_gate.sv
module stby_gate
    import stby_gate_pkg::*;
#(
    parameter int unsigned IDLE_TICKS   = 125000,
    parameter int unsigned SETTLE_TICKS = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_a,
    input  logic cmd_b,
    input  logic uv_flag,
    input  logic ot_flag,
    input  logic ot_cool,
    output logic standby_req,
    output logic wake_clr,
    output logic bridge_ready,
    output logic force_hiz
);
    seq_out_t seq;
    logic     hot_lock;
    logic     prot_off;

    stby_seq #(
        .IDLE_TICKS  (IDLE_TICKS),
        .SETTLE_TICKS(SETTLE_TICKS)
    ) seq_i (
        .clk  (clk),
        .rst  (rst),
        .cmd_a(cmd_a),
        .cmd_b(cmd_b),
        .so   (seq)
    );

    stby_therm therm_i (
        .clk     (clk),
        .rst     (rst),
        .ot_flag (ot_flag),
        .ot_cool (ot_cool),
        .hot_lock(hot_lock)
    );

    assign prot_off     = uv_flag || ot_flag || hot_lock;
    assign standby_req  = seq.sleep;
    assign wake_clr     = seq.wake_pulse;
    assign bridge_ready = seq.run && !prot_off;
    assign force_hiz    = !bridge_ready || (!cmd_a && !cmd_b);

    p_sleep_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
        !(standby_req && bridge_ready));

    p_uv_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        uv_flag |-> (force_hiz && !bridge_ready));

    p_idle_coasts_r4: assert property (@(posedge clk) disable iff (rst)
        (!cmd_a && !cmd_b) |-> force_hiz);

    p_wake_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
        wake_clr |-> !bridge_ready);

endmodule

// File: tb/stby_gate_tb_top.sv
module stby_gate_tb_top;
    localparam int unsigned IDLE   = 8;
    localparam int unsigned SETTLE = 5;
    localparam int NVEC = 11;

    // vector: {a, b, uv, ot, cool, exp_ready, exp_hiz}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b10000_10,  // R8 baseline forward
        7'b01000_10,  // R8 baseline reverse
        7'b11000_10,  // brake
        7'b10100_01,  // R8 undervoltage
        7'b10000_10,  // R8 recovers
        7'b10010_01,  // R9 hot
        7'b10000_01,  // R9 still latched
        7'b10001_10,  // R9 cooled
        7'b10000_10,  // R9 stays clear
        7'b00000_11,  // R4 coast before standby
        7'b10000_10   // R3 count restarts
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_a = 1'b1, cmd_b = 1'b0, uv_flag = 1'b0, ot_flag = 1'b0, ot_cool = 1'b0;
    logic standby_req, wake_clr, bridge_ready, force_hiz;
    int   n_chk = 0;
    int   n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    stby_gate #(.IDLE_TICKS(IDLE), .SETTLE_TICKS(SETTLE)) dut_i (
        .clk(clk), .rst(rst), .cmd_a(cmd_a), .cmd_b(cmd_b),
        .uv_flag(uv_flag), .ot_flag(ot_flag), .ot_cool(ot_cool),
        .standby_req(standby_req), .wake_clr(wake_clr),
        .bridge_ready(bridge_ready), .force_hiz(force_hiz)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        check("R1 standby_req", standby_req, 1'b0);
        check("R1 wake_clr", wake_clr, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            {cmd_a, cmd_b, uv_flag, ot_flag, ot_cool} = VEC[i][6:2];
            cycles(1);
            check("R8/R9/R4 ready vec", bridge_ready, VEC[i][1]);
            check("R8/R9/R4 hiz vec", force_hiz, VEC[i][0]);
        end

        // R4 same-cycle coast, R2 not early, R3 restart
        cmd_a = 1'b0; cmd_b = 1'b0;
        #1 check("R4 immediate coast", force_hiz, 1'b1);
        cycles(IDLE);
        check("R2 no early standby", standby_req, 1'b0);
        cmd_a = 1'b1;
        cycles(1);
        cmd_a = 1'b0;
        cycles(IDLE);
        check("R3 count restarted", standby_req, 1'b0);
        cycles(1);
        check("R2 standby entered", standby_req, 1'b1);
        check("R10 not ready in standby", bridge_ready, 1'b0);
        check("R10 hiz in standby", force_hiz, 1'b1);
        cycles(3);
        check("R5 standby held", standby_req, 1'b1);

        // wake
        cmd_b = 1'b1;
        cycles(1);
        check("R5 standby released", standby_req, 1'b0);
        check("R6 pulse high", wake_clr, 1'b1);
        check("R7 not ready at wake", bridge_ready, 1'b0);
        cycles(1);
        check("R6 pulse one cycle", wake_clr, 1'b0);
        cycles(SETTLE - 2);
        check("R7 still settling", bridge_ready, 1'b0);
        cycles(1);
        check("R7 ready after settle", bridge_ready, 1'b1);
        check("R10 hiz off when ready", force_hiz, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule